// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block is a memory-mapped watchdog peripheral. A free-running timebase counter gives software a way to confirm that the clock is alive. A separate interval counter measures a programmable power-of-two window. The interval counter advances only while two enable bits are both set, and those bits sit in two different control registers. A single stray write therefore cannot start or stop the timer.

Expiry escalates in two stages. When the first window runs out, the block sets a state flag and raises its interrupt. If a second window then runs out with no restart in between, the block issues a one-cycle reset request and latches a reset-cause flag. That flag outlives the watchdog's own reset, so software can read the cause after reboot. Software keeps the timer alive by writing 1 to either status flag. The write clears that flag and restarts the window.

Top module: `escwdt`

## Requirements
- R1: After both resets are released, control word 0 and control word 1 read as zero, and the interrupt and reset-request outputs are low.
- R2: Registers sit at byte offsets 0x0 (control word 0), 0x4 (control word 1) and 0x8 (timebase). In word 0, bit 3 is the reset-cause flag, bit 2 is the state flag, bit 1 is the first enable, and bit 0 mirrors the second enable. In word 1, bit 0 is the second enable. Bit 0 of word 0 is read-only. Any other offset reads zero.
- R3: The timebase counter starts at zero when the reset is released and rises by one on every clock. Writes to its offset have no effect.
- R4: The interval count advances only while both enables are 1. Otherwise it holds its value.
- R5: Once running, the interval expires on the 2^N-th running clock after a restart. A first expiry sets the state flag, and the interrupt output equals the state flag.
- R6: An expiry while the state flag is already set drives the reset request high for exactly one cycle and sets the reset-cause flag. A full escalation therefore takes 2 x 2^N running cycles.
- R7: Writing word 0 with bit 2 or bit 3 at 1 clears the matching flag and restarts the interval. A write in the same cycle as an expiry takes precedence and suppresses that expiry. Writing 0 to either flag bit changes nothing.
- R8: When either enable is 0, the state flag returns to 0 on the next clock. The interval count is kept.
- R9: The reset-cause flag is unaffected by the watchdog reset input. It is cleared only by the power-on reset input or by a write of 1 to its bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous watchdog logic reset |
| porN | input | 1 | Active-low asynchronous power-on reset, clears the reset-cause flag |
| regAddr | input | 4 | Byte offset of the register access |
| wrEn | input | 1 | Write strobe for one cycle |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for regAddr, combinational |
| irqOut | output | 1 | Interrupt, high while the state flag is set |
| rstReqOut | output | 1 | One-cycle system reset request |

## Verification
The hardest case to reach is a keepalive write that lands on the exact clock at which the window expires. Only the write-wins rule tells that case apart from an early or a late keepalive. The stimulus reaches it by issuing a restart and then counting exactly 2^N - 1 idle cycles before the next restart, so the second write meets the expiry edge. A second hard case is a reset-cause flag that must survive a watchdog reset. The bench drives a full two-window escalation, pulses only the watchdog reset, and then reads the flag back through word 0.

// File: rtl/escwdt_pkg.sv
package escwdt_pkg;
  localparam int DATA_W = 32;
  localparam logic [3:0] OFS_CTRL0 = 4'h0;
  localparam logic [3:0] OFS_CTRL1 = 4'h4;
  localparam logic [3:0] OFS_TBASE = 4'h8;
  localparam int BIT_EN2  = 0;
  localparam int BIT_EN1  = 1;
  localparam int BIT_STATE = 2;
  localparam int BIT_CAUSE = 3;

  typedef struct packed {
    logic run;
    logic restart;
  } wdtStrobe_t;
endpackage

// File: rtl/escwdt_datapath.sv
module escwdt_datapath
  import escwdt_pkg::*;
#(
  parameter int INTERVAL_LOG2 = 8,
  parameter int TB_WIDTH = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  wdtStrobe_t          strobe,
  output logic                atLimit,
  output logic [TB_WIDTH-1:0] timebase
);
  logic [INTERVAL_LOG2-1:0] intervalQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intervalQ <= '0;
      timebase  <= '0;
    end else begin
      timebase <= timebase + 1'b1;
      if (strobe.restart) intervalQ <= '0;
      else if (strobe.run) intervalQ <= intervalQ + 1'b1;
    end
  end

  assign atLimit = &intervalQ;

  assert_hold_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.run && !strobe.restart) |=> $stable(intervalQ));

  assert_timebase_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> timebase == TB_WIDTH'($past(timebase) + 1'b1));
endmodule

// File: rtl/escwdt_ctrl.sv
module escwdt_ctrl
  import escwdt_pkg::*;
#(
  parameter int TB_WIDTH = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                porN,
  input  logic [3:0]          regAddr,
  input  logic                wrEn,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                atLimit,
  input  logic [TB_WIDTH-1:0] timebase,
  output wdtStrobe_t          strobe,
  output logic [DATA_W-1:0]   rdData,
  output logic                irqOut,
  output logic                rstReqOut
);
  logic en1Q, en2Q, wdStateQ, causeQ;
  logic wrCtrl0, wrCtrl1, run, restart, expire;

  assign wrCtrl0 = wrEn && (regAddr == OFS_CTRL0);
  assign wrCtrl1 = wrEn && (regAddr == OFS_CTRL1);
  assign run     = en1Q && en2Q;
  assign restart = wrCtrl0 && (wrData[BIT_STATE] || wrData[BIT_CAUSE]);
  assign expire  = run && !restart && atLimit;

  assign strobe.run     = run;
  assign strobe.restart = restart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      en1Q      <= 1'b0;
      en2Q      <= 1'b0;
      wdStateQ  <= 1'b0;
      rstReqOut <= 1'b0;
    end else begin
      if (wrCtrl0) en1Q <= wrData[BIT_EN1];
      if (wrCtrl1) en2Q <= wrData[BIT_EN2];
      if (!run) wdStateQ <= 1'b0;
      else if (wrCtrl0 && wrData[BIT_STATE]) wdStateQ <= 1'b0;
      else if (expire) wdStateQ <= 1'b1;
      rstReqOut <= expire && wdStateQ;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) causeQ <= 1'b0;
    else if (rstN) begin
      if (wrCtrl0 && wrData[BIT_CAUSE]) causeQ <= 1'b0;
      else if (expire && wdStateQ) causeQ <= 1'b1;
    end
  end

  assign irqOut = wdStateQ;

  always_comb begin
    rdData = '0;
    unique case (regAddr)
      OFS_CTRL0: rdData[3:0] = {causeQ, wdStateQ, en1Q, en2Q};
      OFS_CTRL1: rdData[0]   = en2Q;
      OFS_TBASE: rdData      = DATA_W'(timebase);
      default:   rdData      = '0;
    endcase
  end

  assert_req_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    rstReqOut |=> !rstReqOut);

  assert_req_after_stage_R6: assert property (@(posedge clk) disable iff (!rstN)
    rstReqOut |-> ($past(wdStateQ) && causeQ));

  assert_stage_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> !wdStateQ);

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl0 && wrData[BIT_STATE]) |=> !wdStateQ);
endmodule

// File: rtl/escwdt.sv
module escwdt
  import escwdt_pkg::*;
#(
  parameter int INTERVAL_LOG2 = 8,
  parameter int TB_WIDTH = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        porN,
  input  logic [3:0]  regAddr,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        irqOut,
  output logic        rstReqOut
);
  wdtStrobe_t          strobe;
  logic                atLimit;
  logic [TB_WIDTH-1:0] timebase;

  escwdt_ctrl #(.TB_WIDTH(TB_WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .porN(porN), .regAddr(regAddr), .wrEn(wrEn),
    .wrData(wrData), .atLimit(atLimit), .timebase(timebase), .strobe(strobe),
    .rdData(rdData), .irqOut(irqOut), .rstReqOut(rstReqOut)
  );

  escwdt_datapath #(.INTERVAL_LOG2(INTERVAL_LOG2), .TB_WIDTH(TB_WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .atLimit(atLimit), .timebase(timebase)
  );
endmodule

// File: tb/tb_escwdt.sv
`timescale 1ns/1ps
module tb_escwdt;
  localparam int N = 6;
  localparam int P = 1 << N;

  logic clk = 1'b0, rstN = 1'b0, porN = 1'b0, wrEn = 1'b0;
  logic [3:0] regAddr = 4'h0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic irqOut, rstReqOut;

  int checks = 0, fails = 0, cycles = 0;
  int mEn1, mEn2, mState, mCause, mCnt, mReq;
  longint mTb;
  logic [31:0] v1, v2;
  int pulses;

  escwdt #(.INTERVAL_LOG2(N), .TB_WIDTH(32)) dut (
    .clk(clk), .rstN(rstN), .porN(porN), .regAddr(regAddr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut), .rstReqOut(rstReqOut)
  );

  always #2 clk = ~clk;

  // Behavioural reference, updated on each rising edge.
  always @(posedge clk) begin
    int run, restart, expire;
    if (!porN) mCause = 0;
    if (!rstN) begin
      mEn1 = 0; mEn2 = 0; mState = 0; mCnt = 0; mReq = 0; mTb = 0;
    end else begin
      run = mEn1 & mEn2;
      restart = (wrEn && regAddr == 4'h0 && (wrData[2] || wrData[3])) ? 1 : 0;
      expire = (run && !restart && mCnt == P - 1) ? 1 : 0;
      mReq = 0;
      if (wrEn && regAddr == 4'h0) begin
        mEn1 = wrData[1];
        if (wrData[2]) mState = 0;
        if (wrData[3]) mCause = 0;
      end
      if (wrEn && regAddr == 4'h4) mEn2 = wrData[0];
      if (restart) mCnt = 0;
      else if (run) mCnt = (mCnt + 1) % P;
      if (expire) begin
        if (mState) begin mReq = 1; mCause = 1; end
        else mState = 1;
      end
      if (!run) mState = 0;
      mTb = mTb + 1;
    end
  end

  function automatic logic [31:0] expRead(logic [3:0] a);
    case (a)
      4'h0: return {28'd0, mCause[0], mState[0], mEn1[0], mEn2[0]};
      4'h4: return {31'd0, mEn2[0]};
      4'h8: return mTb[31:0];
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk({31'd0, irqOut}, 32'(mState), "R5 irq");
    chk({31'd0, rstReqOut}, 32'(mReq), "R6 reset request");
    chk(rdData, expRead(regAddr), "R2 read data");
  endtask

  task automatic step(input logic [3:0] a, input logic we, input logic [31:0] d);
    @(negedge clk);
    compareAll();
    regAddr = a; wrEn = we; wrData = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      step(4'h0, 1'b0, 32'd0);
      if (rstReqOut) pulses++;
    end
  endtask

  task automatic peek(input logic [3:0] a, output logic [31:0] v);
    step(a, 1'b0, 32'd0);
    #1 v = rdData;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1; porN = 1'b1;
    // R1: reset state
    peek(4'h0, v1); chk(v1, 32'd0, "R1 word0");
    peek(4'h4, v1); chk(v1, 32'd0, "R1 word1");
    chk({31'd0, irqOut}, 32'd0, "R1 irq");
    chk({31'd0, rstReqOut}, 32'd0, "R1 reset request");
    // R3: timebase runs, writes ignored
    peek(4'h8, v1); peek(4'h8, v2); chk(v2, v1 + 1, "R3 timebase step");
    step(4'h8, 1'b1, 32'h0); peek(4'h8, v2); chk(v2, v1 + 3, "R3 write ignored");
    peek(4'hC, v1); chk(v1, 32'd0, "R2 unmapped offset");
    // R4: only one enable -> no expiry
    step(4'h0, 1'b1, 32'h2); idle(P + 16);
    chk({31'd0, irqOut}, 32'd0, "R4 single enable no expiry");
    peek(4'h0, v1); chk(v1, 32'h2, "R2 enable1 bit");
    // R5: both enables, first expiry
    step(4'h4, 1'b1, 32'h1); idle(P + 2);
    chk({31'd0, irqOut}, 32'd1, "R5 first expiry irq");
    peek(4'h0, v1); chk(v1, 32'h7, "R5 state flag");
    // R7: writing 0 to flag bit leaves it, writing 1 clears
    step(4'h0, 1'b1, 32'h2); peek(4'h0, v1); chk(v1, 32'h7, "R7 zero write no effect");
    step(4'h0, 1'b1, 32'h6); peek(4'h0, v1); chk(v1, 32'h3, "R7 clear state");
    // R7: restart coinciding with expiry edge
    step(4'h0, 1'b1, 32'h6); idle(P - 1); step(4'h0, 1'b1, 32'h6);
    peek(4'h0, v1); chk(v1, 32'h3, "R7 write wins over expiry");
    // R6: full escalation
    pulses = 0; idle(2 * P + 4);
    chk(32'(pulses), 32'd1, "R6 single reset pulse");
    peek(4'h0, v1); chk(v1[3:2], 2'b11, "R6 cause flag set");
    // R9: watchdog reset keeps the cause flag
    @(negedge clk); rstN = 1'b0; repeat (2) @(negedge clk); rstN = 1'b1;
    peek(4'h0, v1); chk(v1, 32'h8, "R9 cause survives reset");
    step(4'h0, 1'b1, 32'h8); peek(4'h0, v1); chk(v1, 32'h0, "R9 cause write clear");
    // R8: dropping an enable returns to initial stage
    step(4'h0, 1'b1, 32'h2); step(4'h4, 1'b1, 32'h1); idle(P + 2);
    chk({31'd0, irqOut}, 32'd1, "R8 precondition");
    step(4'h4, 1'b1, 32'h0); idle(4);
    chk({31'd0, irqOut}, 32'd0, "R8 state cleared");
    step(4'h4, 1'b1, 32'h1); idle(P + 2);
    chk({31'd0, irqOut}, 32'd1, "R8 resumes from held count");
    // R9: power-on reset clears the cause flag
    idle(P + 2); peek(4'h0, v1); chk(v1[3], 1'b1, "R9 cause before power-on");
    @(negedge clk); rstN = 1'b0; porN = 1'b0; repeat (2) @(negedge clk);
    rstN = 1'b1; porN = 1'b1;
    peek(4'h0, v1); chk(v1, 32'h0, "R9 power-on clears cause");
    idle(4);
    finishRun();
  end
endmodule